// File: doc/BRIEF.md
# Two-Wire Serial Programming Target

This block is the target side of a two-wire serial programming port. A host toggles a serial clock and a data line; the block samples both on its own system clock, decodes 6-bit commands and moves 16-cycle data frames into and out of a 14-bit transfer latch. An address pointer selects a word in either the user memory space or a separate configuration space. A programming pulse ANDs the latch into the addressed word of a small behavioural one-time-programmable array, whose erased value is all ones.

Programming mode is entered when the high-voltage entry input rises while serial clock and data are both low. Entry puts the pointer at 0 in user space. User word n lives at pointer 0x10 + n. A Load Configuration command moves the pointer into configuration space, where the single configuration word sits at pointer 7. Only dropping the entry input and entering again brings the pointer back to user space.

Top module: `serprog_target`

## Requirements
- R1: Programming mode is entered only on a rise of `hv_entry_i` while `pgm_clk_i` and `pgm_dat_i` are both low. Outside programming mode every command is ignored.
- R2: A command is 6 bits, sampled on falling edges of `pgm_clk_i`, least significant bit first. The 6-bit codes are: 0x00 load configuration, 0x02 load data, 0x04 read, 0x06 increment address, 0x08 begin programming, 0x0E end programming. Any other code has no effect.
- R3: On entry the pointer is 0. Increment adds 1 to it. User word n is addressed at pointer 0x10 + n.
- R4: A load frame is 16 falling-edge samples. The start bit comes first and must be 0. Then 14 data bits follow, least significant bit first. The stop bit comes last and must be 1. A valid frame replaces the transfer latch.
- R5: A load frame with a start bit of 1 or a stop bit of 0 leaves the transfer latch unchanged.
- R6: When a read command completes, the addressed word is copied into the latch. In the following frame `pgm_dat_oe` rises at rising edge 2, and rising edge k drives latch bit k-2 on `pgm_dat_o` for k = 2..15. The pin is released at rising edge 16.
- R7: `prog_pulse_o` rises when begin programming is decoded and falls when end programming is decoded. A repeated begin while the pulse is active writes nothing.
- R8: Erased words read 0x3FFF. Each begin programming ANDs the latch into the addressed word, so bits are only cleared.
- R9: Load configuration selects configuration space and, on that switch, sets the pointer to 0. The configuration word is at pointer 7 and holds only bits 2:0, which come from latch bits 2:0. It reads back with bits 13:3 set to 1.
- R10: Once configuration space is selected, it stays selected until `hv_entry_i` goes low. After re-entry the block is in user space again.
- R11: A pointer value with no cell behind it reads 0x3FFF, and programming at such a value changes no stored word. In user space these are values below 0x10 or past the last user word; in configuration space, every value other than 7.
- R12: With `hv_entry_i` low, `prog_pulse_o` and `pgm_dat_oe` are low, even if that input drops in the middle of a pulse or a read frame.
- R13: After `rst_n`, `pgm_dat_oe` and `prog_pulse_o` are low, and every stored word is erased.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_entry_i | input | 1 | Programming-mode entry level, high while in programming mode |
| pgm_clk_i | input | 1 | Serial programming clock from the host |
| pgm_dat_i | input | 1 | Serial data from the host |
| pgm_dat_o | output | 1 | Serial read data toward the host |
| pgm_dat_oe | output | 1 | Output enable for the data pin |
| prog_pulse_o | output | 1 | Programming pulse strobe, high between begin and end |

## Verification
Words are programmed with mixed bit patterns such as 0x2A5C, then programmed again with an overlapping pattern. The second result can only come from an AND, so it tells a clearing-only cell apart from a plain overwrite. Frames with a bad start bit and with a bad stop bit are sent ahead of a good frame; the target word then shows whether each bad frame reached the latch. The configuration word and a pointer value that would hit a programmed user word in the other space are both read back, so a block that forgot its space select returns a visibly different word. Each read also checks the output-enable window bit by bit, which catches a turnaround one edge early or one edge late.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

    localparam int WORD_W    = 14;
    localparam int CMD_LEN   = 6;
    localparam int FRAME_LEN = WORD_W + 2;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef enum logic [CMD_LEN-1:0] {
        CMD_LD_CFG  = 6'h00,
        CMD_LD_DATA = 6'h02,
        CMD_READ    = 6'h04,
        CMD_INCR    = 6'h06,
        CMD_BEGIN   = 6'h08,
        CMD_END     = 6'h0E
    } cmd_e;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/serprog_pin_sync.sv
module serprog_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serprog_cell_array.sv
// Behavioural clear-only storage: every write ANDs into the stored word.
module serprog_cell_array #(
    parameter int WIDTH  = 14,
    parameter int DEPTH  = 70,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  rdata_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W + 1)'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic             in_range;
    logic [AW-1:0]    idx;

    assign in_range = ({1'b0, addr_i} < DEPTH_L);
    assign idx      = AW'(addr_i);

    always_comb begin
        mem_d = mem_q;
        if (we_i && in_range) begin
            mem_d[idx] = mem_q[idx] & wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = in_range ? mem_q[idx] : '1;
endmodule

// File: rtl/serprog_target.sv
module serprog_target
    import serprog_pkg::*;
#(
    parameter int PTR_W       = 8,
    parameter int USER_BASE   = 16,
    parameter int USER_DEPTH  = 70,
    parameter int CFG_SLOT    = 7,
    parameter int CFG_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hv_entry_i,
    input  logic pgm_clk_i,
    input  logic pgm_dat_i,
    output logic pgm_dat_o,
    output logic pgm_dat_oe,
    output logic prog_pulse_o
);
    localparam logic [PTR_W-1:0]  BASE_P  = PTR_W'(USER_BASE);
    localparam logic [PTR_W-1:0]  DEPTH_P = PTR_W'(USER_DEPTH);
    localparam logic [PTR_W-1:0]  SLOT_P  = PTR_W'(CFG_SLOT);
    localparam logic [CNT_W-1:0]  CMD_END_CNT   = CNT_W'(CMD_LEN - 1);
    localparam logic [CNT_W-1:0]  FRAME_END_CNT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0]  OE_ON_RISE    = CNT_W'(2);
    localparam logic [CNT_W-1:0]  OE_OFF_RISE   = CNT_W'(FRAME_LEN);

    typedef struct packed {
        logic                  mode;
        logic                  clk_prev;
        logic                  hv_prev;
        phase_e                phase;
        logic [CMD_LEN-1:0]    cmd_sh;
        cmd_e                  cur;
        logic [CNT_W-1:0]      fcnt;
        logic [CNT_W-1:0]      rcnt;
        logic [FRAME_LEN-1:0]  fr_sh;
        logic [WORD_W-1:0]     latch;
        logic [WORD_W-1:0]     rd_sh;
        logic [PTR_W-1:0]      ptr;
        logic                  in_cfg;
        logic                  pulse;
        logic                  oe;
        logic                  dout;
    } state_t;

    state_t s_d, s_q;

    // synchronised pins
    logic [2:0] pins_s;
    logic       hv_s, pclk_s, pdat_s;

    serprog_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({hv_entry_i, pgm_clk_i, pgm_dat_i}),
        .q_o   (pins_s)
    );
    assign {hv_s, pclk_s, pdat_s} = pins_s;

    // address decode
    logic [PTR_W-1:0]  user_idx;
    logic              user_hit, cfg_hit;
    logic [WORD_W-1:0] user_rdata;
    logic [CFG_W-1:0]  cfg_rdata;
    logic [WORD_W-1:0] rd_word;
    logic              we_user, we_cfg;

    assign user_idx = s_q.ptr - BASE_P;
    assign user_hit = (s_q.ptr >= BASE_P) && (user_idx < DEPTH_P);
    assign cfg_hit  = (s_q.ptr == SLOT_P);

    always_comb begin
        rd_word = '1;
        if (s_q.in_cfg) begin
            if (cfg_hit) rd_word = {{(WORD_W-CFG_W){1'b1}}, cfg_rdata};
        end else if (user_hit) begin
            rd_word = user_rdata;
        end
    end

    serprog_cell_array #(.WIDTH(WORD_W), .DEPTH(USER_DEPTH), .ADDR_W(PTR_W)) i_user_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (user_idx),
        .we_i    (we_user),
        .wdata_i (s_q.latch),
        .rdata_o (user_rdata)
    );

    serprog_cell_array #(.WIDTH(CFG_W), .DEPTH(1), .ADDR_W(PTR_W)) i_cfg_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (s_q.ptr - SLOT_P),
        .we_i    (we_cfg),
        .wdata_i (s_q.latch[CFG_W-1:0]),
        .rdata_o (cfg_rdata)
    );

    // edge detect on the synchronised serial clock
    logic clk_fall, clk_rise;
    assign clk_fall = s_q.clk_prev && !pclk_s;
    assign clk_rise = !s_q.clk_prev && pclk_s;

    logic [CMD_LEN-1:0]   cmd_full;
    logic [FRAME_LEN-1:0] frame_full;
    logic [CNT_W-1:0]     rise_next;
    assign cmd_full   = {pdat_s, s_q.cmd_sh[CMD_LEN-1:1]};
    assign frame_full = {pdat_s, s_q.fr_sh[FRAME_LEN-1:1]};
    assign rise_next  = s_q.rcnt + 1'b1;

    always_comb begin
        s_d          = s_q;
        we_user      = 1'b0;
        we_cfg       = 1'b0;
        s_d.clk_prev = pclk_s;
        s_d.hv_prev  = hv_s;

        if (!hv_s) begin
            // leaving programming mode clears everything but storage and latch
            s_d.mode   = 1'b0;
            s_d.pulse  = 1'b0;
            s_d.oe     = 1'b0;
            s_d.dout   = 1'b0;
            s_d.in_cfg = 1'b0;
            s_d.ptr    = '0;
            s_d.phase  = PH_CMD;
            s_d.fcnt   = '0;
            s_d.rcnt   = '0;
            s_d.cmd_sh = '0;
        end else if (!s_q.mode) begin
            if (!s_q.hv_prev && !pclk_s && !pdat_s) begin
                s_d.mode   = 1'b1;
                s_d.in_cfg = 1'b0;
                s_d.ptr    = '0;
                s_d.phase  = PH_CMD;
                s_d.fcnt   = '0;
                s_d.rcnt   = '0;
                s_d.cmd_sh = '0;
            end
        end else begin
            if (clk_fall) begin
                if (s_q.phase == PH_CMD) begin
                    s_d.cmd_sh = cmd_full;
                    s_d.fcnt   = s_q.fcnt + 1'b1;
                    if (s_q.fcnt == CMD_END_CNT) begin
                        s_d.fcnt = '0;
                        s_d.rcnt = '0;
                        case (cmd_full)
                            CMD_LD_CFG: begin
                                if (!s_q.in_cfg) begin
                                    s_d.in_cfg = 1'b1;
                                    s_d.ptr    = '0;
                                end
                                s_d.phase = PH_DATA;
                                s_d.cur   = CMD_LD_CFG;
                            end
                            CMD_LD_DATA: begin
                                s_d.phase = PH_DATA;
                                s_d.cur   = CMD_LD_DATA;
                            end
                            CMD_READ: begin
                                s_d.phase = PH_DATA;
                                s_d.cur   = CMD_READ;
                                s_d.latch = rd_word;
                                s_d.rd_sh = rd_word;
                            end
                            CMD_INCR: begin
                                s_d.ptr = s_q.ptr + 1'b1;
                            end
                            CMD_BEGIN: begin
                                if (!s_q.pulse) begin
                                    s_d.pulse = 1'b1;
                                    we_user   = !s_q.in_cfg && user_hit;
                                    we_cfg    = s_q.in_cfg && cfg_hit;
                                end
                            end
                            CMD_END: begin
                                s_d.pulse = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end else begin
                    s_d.fr_sh = frame_full;
                    s_d.fcnt  = s_q.fcnt + 1'b1;
                    if (s_q.fcnt == FRAME_END_CNT) begin
                        s_d.fcnt  = '0;
                        s_d.phase = PH_CMD;
                        s_d.oe    = 1'b0;
                        s_d.dout  = 1'b0;
                        if (s_q.cur != CMD_READ && !frame_full[0]
                            && frame_full[FRAME_LEN-1]) begin
                            s_d.latch = frame_full[FRAME_LEN-2:1];
                        end
                    end
                end
            end else if (clk_rise && s_q.phase == PH_DATA && s_q.cur == CMD_READ) begin
                s_d.rcnt = rise_next;
                if (rise_next == OE_OFF_RISE) begin
                    s_d.oe   = 1'b0;
                    s_d.dout = 1'b0;
                end else if (rise_next >= OE_ON_RISE) begin
                    s_d.oe    = 1'b1;
                    s_d.dout  = s_q.rd_sh[0];
                    s_d.rd_sh = {1'b0, s_q.rd_sh[WORD_W-1:1]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{
                mode:     1'b0,
                clk_prev: 1'b0,
                hv_prev:  1'b0,
                phase:    PH_CMD,
                cmd_sh:   '0,
                cur:      CMD_LD_DATA,
                fcnt:     '0,
                rcnt:     '0,
                fr_sh:    '0,
                latch:    '1,
                rd_sh:    '0,
                ptr:      '0,
                in_cfg:   1'b0,
                pulse:    1'b0,
                oe:       1'b0,
                dout:     1'b0
            };
        end else begin
            s_q <= s_d;
        end
    end

    assign pgm_dat_o    = s_q.dout;
    assign pgm_dat_oe   = s_q.oe;
    assign prog_pulse_o = s_q.pulse;

    // observation points for the bound checker
    logic mode_w, cfg_w, pins_quiet_w;
    assign mode_w       = s_q.mode;
    assign cfg_w        = s_q.in_cfg;
    assign pins_quiet_w = !pclk_s && !pdat_s;
endmodule

// File: rtl/serprog_target_chk.sv
module serprog_target_chk (
    input logic clk,
    input logic rst_n,
    input logic mode,
    input logic in_cfg,
    input logic pulse,
    input logic oe,
    input logic we_user,
    input logic we_cfg,
    input logic clk_rise,
    input logic pins_quiet
);
    assert_entry_quiet_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode) |-> $past(pins_quiet));

    assert_oe_follows_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(clk_rise));

    assert_write_opens_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_user || we_cfg) |=> pulse);

    assert_one_space_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_user && we_cfg));

    assert_user_write_in_user_space_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we_user |-> !in_cfg);

    assert_cfg_space_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cfg && mode) |=> (in_cfg || !mode));

    assert_idle_outside_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (!pulse && !oe));
endmodule

bind serprog_target serprog_target_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_w),
    .in_cfg     (cfg_w),
    .pulse      (prog_pulse_o),
    .oe         (pgm_dat_oe),
    .we_user    (we_user),
    .we_cfg     (we_cfg),
    .clk_rise   (clk_rise),
    .pins_quiet (pins_quiet_w)
);

// File: tb/test_serprog_target.sv
`timescale 1ns/1ps
module test_serprog_target;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hv = 1'b0;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic dat_o, dat_oe, pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serprog_target i_serprog_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .hv_entry_i   (hv),
        .pgm_clk_i    (sclk),
        .pgm_dat_i    (sdat),
        .pgm_dat_o    (dat_o),
        .pgm_dat_oe   (dat_oe),
        .prog_pulse_o (pulse)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(input logic b);
        cyc(1); sdat = b;
        cyc(3); sclk = 1'b1;
        cyc(HALF); sclk = 1'b0;
        cyc(HALF);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) ser_bit(c[i]);
        sdat = 1'b0;
        cyc(6);
    endtask

    task automatic load_frame(input logic [13:0] v, input logic st, input logic sp);
        ser_bit(st);
        for (int i = 0; i < 14; i++) ser_bit(v[i]);
        ser_bit(sp);
        sdat = 1'b0;
        cyc(6);
    endtask

    task automatic read_word(input string req, input int exp);
        logic [13:0] v;
        int oe_bad;
        v = '0;
        oe_bad = 0;
        send_cmd(6'h04);
        for (int k = 1; k <= 16; k++) begin
            cyc(1); sdat = 1'b0;
            cyc(3); sclk = 1'b1;
            cyc(HALF - 2);
            if (dat_oe != ((k >= 2) && (k <= 15))) oe_bad++;
            if (k >= 2 && k <= 15) v[k-2] = dat_o;
            cyc(2); sclk = 1'b0;
            cyc(HALF);
        end
        cyc(6);
        check_eq("R6", "output enable window", oe_bad, 0);
        check_eq(req, "read word", int'(v), exp);
    endtask

    task automatic incr(input int n);
        for (int i = 0; i < n; i++) send_cmd(6'h06);
    endtask

    task automatic pulse_once(input string req);
        send_cmd(6'h08);
        check_eq(req, "pulse after begin", int'(pulse), 1);
        send_cmd(6'h0E);
        check_eq(req, "pulse after end", int'(pulse), 0);
    endtask

    task automatic program_word(input logic [13:0] v);
        send_cmd(6'h02);
        load_frame(v, 1'b0, 1'b1);
        pulse_once("R7");
    endtask

    task automatic enter_mode();
        hv = 1'b0; sclk = 1'b0; sdat = 1'b0;
        cyc(10);
        hv = 1'b1;
        cyc(10);
    endtask

    task automatic leave_mode();
        hv = 1'b0;
        cyc(10);
    endtask

    task automatic t_reset();
        check_eq("R13", "oe after reset", int'(dat_oe), 0);
        check_eq("R13", "pulse after reset", int'(pulse), 0);
    endtask

    task automatic t_user_program();
        enter_mode();
        incr(16);                             // R3: user word 0 at pointer 0x10
        read_word("R8", 14'h3FFF);
        program_word(14'h2A5C);               // R2, R4 LSB-first framing
        read_word("R4", 14'h2A5C);
        program_word(14'h0FF0);
        read_word("R8", 14'h0A50);            // AND of the two patterns
        send_cmd(6'h08);                      // R7 repeated begin writes nothing
        send_cmd(6'h3F);                      // R2 unknown code has no effect
        send_cmd(6'h08);
        send_cmd(6'h0E);
        read_word("R7", 14'h0A50);
        incr(1);
        read_word("R3", 14'h3FFF);
    endtask

    task automatic t_bad_frame();
        // latch holds 0x3FFF from the last read of user word 1
        send_cmd(6'h02);
        load_frame(14'h0000, 1'b1, 1'b1);     // bad start bit
        pulse_once("R5");
        read_word("R5", 14'h3FFF);
        send_cmd(6'h02);
        load_frame(14'h0000, 1'b0, 1'b0);     // bad stop bit
        pulse_once("R5");
        read_word("R5", 14'h3FFF);
        program_word(14'h1234);
        read_word("R4", 14'h1234);
    endtask

    task automatic t_no_cell();
        leave_mode();
        enter_mode();
        program_word(14'h0000);               // pointer 0: no cell
        read_word("R11", 14'h3FFF);
        incr(16);
        read_word("R11", 14'h0A50);
    endtask

    task automatic t_config();
        leave_mode();
        enter_mode();
        send_cmd(6'h00);
        load_frame(14'h3FFA, 1'b0, 1'b1);
        incr(7);
        pulse_once("R9");
        read_word("R9", 14'h3FFA);
        incr(9);                              // pointer 16 in config space
        read_word("R10", 14'h3FFF);
        leave_mode();
        enter_mode();
        incr(16);
        read_word("R10", 14'h0A50);
        leave_mode();
        enter_mode();
        send_cmd(6'h00);
        load_frame(14'h0005, 1'b0, 1'b1);     // only bits 2:0 are kept
        incr(7);
        pulse_once("R9");
        read_word("R9", 14'h3FF8);
    endtask

    task automatic t_entry();
        leave_mode();
        sdat = 1'b1;
        cyc(6);
        hv = 1'b1;                            // rise with data high
        cyc(10);
        sdat = 1'b0;
        cyc(4);
        send_cmd(6'h08);
        check_eq("R1", "pulse without valid entry", int'(pulse), 0);
        enter_mode();
        incr(16);
        read_word("R1", 14'h0A50);
    endtask

    task automatic t_drop();
        send_cmd(6'h08);
        check_eq("R12", "pulse before drop", int'(pulse), 1);
        leave_mode();
        check_eq("R12", "pulse after drop", int'(pulse), 0);
        enter_mode();
        send_cmd(6'h04);
        for (int k = 1; k <= 4; k++) ser_bit(1'b0);
        check_eq("R6", "oe mid read frame", int'(dat_oe), 1);
        leave_mode();
        check_eq("R12", "oe after drop", int'(dat_oe), 0);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        t_reset();
        t_user_program();
        t_bad_frame();
        t_no_cell();
        t_config();
        t_entry();
        t_drop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule